// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block is the message-passing space that sits next to a shared dual-port memory. Two processors, side A and side B, each own four 16-bit mailboxes. A side may write its mailboxes a byte at a time and read them back. The other side may only read them. When a side writes the upper byte of one of its mailboxes, a notification for that mailbox is raised at the other side. The receiving side acknowledges the notification by reading the upper byte of that same mailbox through its peer window. The acknowledgement leaves the mailbox contents as they were.

Each side has a 4-bit mask and a control word it can read. The control word packs three groups of bits. The first group is the mask. The second is a post-mask cause group, which records only the sources that were unmasked when they fired. The third is a pre-mask status group, which records every source that fired. Cause and status bits read as 0 for a source that has fired. Each side drives an active-low interrupt line.

An access is one clock cycle with the side's select strobe high. The write-enable input picks read or write, and two byte enables qualify the access. Read data is registered.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: A write to a side's own mailbox window (address 0x20 + n, n = 0..3) stores the low byte when byte enable bit 0 is set and the high byte when byte enable bit 1 is set. Bytes that are not enabled keep their value. A read of the same address returns the stored word.
- R2: A read of the peer window (address 0x24 + n) returns the other side's mailbox n. The read does not change that mailbox.
- R3: A write to own mailbox n with byte enable bit 1 set raises source n at the other side. A write with only bit 0 set raises nothing.
- R4: A side reading back its own mailbox does not change any notification it has sent.
- R5: A read of peer window n with byte enable bit 1 set clears source n (both cause and status) at the reading side. A read with only bit 0 set leaves that source pending.
- R6: The control word at address 0x28 reads as {4'b0000, status[3:0], cause[3:0], mask[3:0]}, with status and cause active-low. A write to 0x28 with byte enable bit 0 set loads all four mask bits from write data bits 3:0. A write to 0x28 without byte enable bit 0 leaves the mask unchanged. A side changes only its own mask.
- R7: A source that fires while masked (mask bit = 1) updates its status bit but not its cause bit. An unmasked source updates both bits.
- R8: The interrupt output is low exactly while some cause bit is set and its mask bit is 0. Masking a pending cause releases the line, and unmasking it drives the line low again.
- R9: Writes to any other address in the 6-bit space change no mailbox, mask or flag.
- R10: Reset (synchronous, active high) clears every mailbox to 0, sets every mask bit to 1, clears all flags, drives both interrupt outputs high and clears the read data.
- R11: A set and a clear of the same source in the same cycle leave that source pending. A peer read made in the same cycle as a write returns the data the mailbox held before the write.
- R12: Read data changes only after a read access. It holds its value across write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 1 | Side A access strobe |
| a_addr | input | 6 | Side A address |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_be | input | 2 | Side A byte enables, bit 1 = upper byte |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A registered read data |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_sel | input | 1 | Side B access strobe |
| b_addr | input | 6 | Side B address |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_be | input | 2 | Side B byte enables, bit 1 = upper byte |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B registered read data |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
Each access is taken at one rising edge, and every result it causes appears after that same edge. Those results are the read data, the mailbox contents, the mask, the flags and the interrupt line of either side. No result waits an additional cycle. The bench applies one access per cycle from a falling edge and checks both interrupt lines and the read data at the next falling edge, half a cycle after the edge that took the access. State that is not visible at the ports is brought out by reading the control word or the mailboxes on a later access. The same-cycle collision of a set and a clear is driven on both sides in a single cycle and checked the same way.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MB_CNT = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = $clog2(MB_CNT);
    localparam int BYTE_W = DATA_W / 2;
    localparam int PAD_W  = DATA_W - 3 * MB_CNT;

    localparam logic [ADDR_W-1:0] OWN_BASE  = 6'h20;
    localparam logic [ADDR_W-1:0] PEER_BASE = 6'h24;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h28;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_OWN,
        ACC_PEER,
        ACC_CTRL
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } acc_dec_t;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [1:0]        be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } port_req_t;

    function automatic acc_dec_t mbox_decode(input logic [ADDR_W-1:0] addr);
        acc_dec_t d;
        d.idx  = addr[IDX_W-1:0];
        d.kind = ACC_NONE;
        if (addr[ADDR_W-1:IDX_W] == OWN_BASE[ADDR_W-1:IDX_W])
            d.kind = ACC_OWN;
        else if (addr[ADDR_W-1:IDX_W] == PEER_BASE[ADDR_W-1:IDX_W])
            d.kind = ACC_PEER;
        else if (addr == CTRL_ADDR)
            d.kind = ACC_CTRL;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(
        input logic [MB_CNT-1:0] mask,
        input logic [MB_CNT-1:0] cause,
        input logic [MB_CNT-1:0] status
    );
        return {{PAD_W{1'b0}}, ~status, ~cause, mask};
    endfunction

endpackage

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
#(
    parameter int N = MB_CNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] cause_o
);

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                status_o[i] <= 1'b0;
            else if (set_i[i])
                status_o[i] <= 1'b1;
            else if (clr_i[i])
                status_o[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                cause_o[i] <= 1'b0;
            else if (set_i[i] && !mask_i[i])
                cause_o[i] <= 1'b1;
            else if (clr_i[i] && !set_i[i])
                cause_o[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int N  = MB_CNT,
    parameter int DW = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  port_req_t             req_i,
    input  logic [N-1:0]          peer_set_i,
    input  logic [N-1:0][DW-1:0]  peer_mbox_i,
    output logic [N-1:0][DW-1:0]  own_mbox_o,
    output logic [N-1:0]          own_set_o,
    output logic [DW-1:0]         rdata_o,
    output logic                  irq_n_o,
    output logic [N-1:0]          mask_o,
    output logic [N-1:0]          status_o,
    output logic [N-1:0]          cause_o
);

    localparam int HB = DW / 2;

    acc_dec_t     dec;
    logic         is_rd;
    logic         is_wr;
    logic [N-1:0] clr;

    assign dec   = mbox_decode(req_i.addr);
    assign is_rd = req_i.sel && !req_i.wr;
    assign is_wr = req_i.sel && req_i.wr;

    for (genvar i = 0; i < N; i++) begin : g_mb
        logic hit_own;
        logic hit_peer;
        assign hit_own  = (dec.kind == ACC_OWN)  && (dec.idx == i);
        assign hit_peer = (dec.kind == ACC_PEER) && (dec.idx == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                own_mbox_o[i] <= '0;
            end else if (is_wr && hit_own) begin
                if (req_i.be[0]) own_mbox_o[i][HB-1:0]  <= req_i.wdata[HB-1:0];
                if (req_i.be[1]) own_mbox_o[i][DW-1:HB] <= req_i.wdata[DW-1:HB];
            end
        end

        assign own_set_o[i] = is_wr && hit_own  && req_i.be[1];
        assign clr[i]       = is_rd && hit_peer && req_i.be[1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= '1;
        else if (is_wr && dec.kind == ACC_CTRL && req_i.be[0])
            mask_o <= req_i.wdata[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (is_rd) begin
            unique case (dec.kind)
                ACC_OWN:  rdata_o <= own_mbox_o[dec.idx];
                ACC_PEER: rdata_o <= peer_mbox_i[dec.idx];
                ACC_CTRL: rdata_o <= ctrl_word(mask_o, cause_o, status_o);
                default:  rdata_o <= '0;
            endcase
        end
    end

    mbox_flags #(.N(N)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (peer_set_i),
        .clr_i    (clr),
        .mask_i   (mask_o),
        .status_o (status_o),
        .cause_o  (cause_o)
    );

    assign irq_n_o = ~|(cause_o & ~mask_o);

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_sel,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic [1:0]        a_be,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_sel,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic [1:0]        b_be,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam int SIDES = 2;

    port_req_t [SIDES-1:0]                     req;
    logic [SIDES-1:0][MB_CNT-1:0][DATA_W-1:0]  mbox_all;
    logic [SIDES-1:0][MB_CNT-1:0]              set_all;
    logic [SIDES-1:0][MB_CNT-1:0]              mask_all;
    logic [SIDES-1:0][MB_CNT-1:0]              stat_all;
    logic [SIDES-1:0][MB_CNT-1:0]              cause_all;
    logic [SIDES-1:0][DATA_W-1:0]              rd_all;
    logic [SIDES-1:0]                          irq_all;

    assign req[0] = '{sel: a_sel, wr: a_wr, be: a_be, addr: a_addr, wdata: a_wdata};
    assign req[1] = '{sel: b_sel, wr: b_wr, be: b_be, addr: b_addr, wdata: b_wdata};

    for (genvar p = 0; p < SIDES; p++) begin : g_side
        mbox_side #(.N(MB_CNT), .DW(DATA_W)) u_side (
            .clk         (clk),
            .rst         (rst),
            .req_i       (req[p]),
            .peer_set_i  (set_all[SIDES-1-p]),
            .peer_mbox_i (mbox_all[SIDES-1-p]),
            .own_mbox_o  (mbox_all[p]),
            .own_set_o   (set_all[p]),
            .rdata_o     (rd_all[p]),
            .irq_n_o     (irq_all[p]),
            .mask_o      (mask_all[p]),
            .status_o    (stat_all[p]),
            .cause_o     (cause_all[p])
        );
    end

    assign a_rdata = rd_all[0];
    assign b_rdata = rd_all[1];
    assign a_irq_n = irq_all[0];
    assign b_irq_n = irq_all[1];

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              a_sel,
    input logic              a_wr,
    input logic              a_be_hi,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_irq_n,
    input logic              b_sel,
    input logic              b_wr,
    input logic              b_be_hi,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_irq_n,
    input logic [MB_CNT-1:0] st_a,
    input logic [MB_CNT-1:0] st_b,
    input logic [MB_CNT-1:0] cs_a,
    input logic [MB_CNT-1:0] cs_b,
    input logic [MB_CNT-1:0] mk_a,
    input logic [MB_CNT-1:0] mk_b
);

    logic a_up_own, b_up_peer, a_resv_wr, b_resv_wr;
    assign a_up_own  = a_sel && a_wr && a_be_hi &&
                       (a_addr[ADDR_W-1:IDX_W] == OWN_BASE[ADDR_W-1:IDX_W]);
    assign b_up_peer = b_sel && !b_wr && b_be_hi &&
                       (b_addr[ADDR_W-1:IDX_W] == PEER_BASE[ADDR_W-1:IDX_W]);
    assign a_resv_wr = a_sel && a_wr && (a_addr[ADDR_W-1:IDX_W+1] != OWN_BASE[ADDR_W-1:IDX_W+1])
                       && (a_addr != CTRL_ADDR);
    assign b_resv_wr = b_sel && b_wr && (b_addr[ADDR_W-1:IDX_W+1] != OWN_BASE[ADDR_W-1:IDX_W+1])
                       && (b_addr != CTRL_ADDR);

    assert_upper_write_sets_R3: assert property (@(posedge clk) disable iff (rst)
        a_up_own |=> st_b[$past(a_addr[IDX_W-1:0])]);

    assert_upper_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (b_up_peer && !(a_sel && a_wr)) |=> !st_b[$past(b_addr[IDX_W-1:0])]);

    assert_cause_within_status_R7: assert property (@(posedge clk) disable iff (rst)
        ((cs_a & ~st_a) == '0) && ((cs_b & ~st_b) == '0));

    assert_irq_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!a_sel && !b_sel) |=> ($stable(a_irq_n) && $stable(b_irq_n)));

    assert_reserved_write_keeps_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (a_resv_wr && !b_resv_wr) |=> ($stable(mk_a) && $stable(mk_b)));

    assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (rst)
        !(a_sel && !a_wr) |=> $stable(a_rdata));

    assert_rdata_holds_b_R12: assert property (@(posedge clk) disable iff (rst)
        !(b_sel && !b_wr) |=> $stable(b_rdata));

endmodule

bind mbox_irq_ctrl mbox_checker u_mbox_checker (
    .clk     (clk),
    .rst     (rst),
    .a_sel   (a_sel),
    .a_wr    (a_wr),
    .a_be_hi (a_be[1]),
    .a_addr  (a_addr),
    .a_rdata (a_rdata),
    .a_irq_n (a_irq_n),
    .b_sel   (b_sel),
    .b_wr    (b_wr),
    .b_be_hi (b_be[1]),
    .b_addr  (b_addr),
    .b_rdata (b_rdata),
    .b_irq_n (b_irq_n),
    .st_a    (stat_all[0]),
    .st_b    (stat_all[1]),
    .cs_a    (cause_all[0]),
    .cs_b    (cause_all[1]),
    .mk_a    (mask_all[0]),
    .mk_b    (mask_all[1])
);

// File: tb/test_mbox_irq_ctrl.sv
module test_mbox_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_sel = 1'b0, b_sel = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic        a_wr = 1'b0, b_wr = 1'b0;
    logic [1:0]  a_be = '0, b_be = '0;
    logic [15:0] a_wdata = '0, b_wdata = '0;
    logic [15:0] a_rdata, b_rdata;
    logic        a_irq_n, b_irq_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mbox_irq_ctrl i_mbox_irq_ctrl (
        .clk(clk), .rst(rst),
        .a_sel(a_sel), .a_addr(a_addr), .a_wr(a_wr), .a_be(a_be),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_sel(b_sel), .b_addr(b_addr), .b_wr(b_wr), .b_be(b_be),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    // port 0 = side A, 1 = side B; irq field is {b_irq_n, a_irq_n}
    typedef struct packed {
        logic        port;
        logic        wr;
        logic [1:0]  be;
        logic [5:0]  addr;
        logic [15:0] wd;
        logic        chk;
        logic [15:0] rd;
        logic [1:0]  irq;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 2'b01, 6'h28, 16'h0000, 1'b0, 16'h0000, 2'b11, "R6"},
        '{1'b1, 1'b1, 2'b01, 6'h28, 16'h0000, 1'b0, 16'h0000, 2'b11, "R6"},
        '{1'b0, 1'b1, 2'b11, 6'h20, 16'h1234, 1'b0, 16'h0000, 2'b01, "R3"},
        '{1'b0, 1'b0, 2'b11, 6'h20, 16'h0000, 1'b1, 16'h1234, 2'b01, "R4"},
        '{1'b1, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h0EE0, 2'b01, "R6"},
        '{1'b1, 1'b0, 2'b01, 6'h24, 16'h0000, 1'b1, 16'h1234, 2'b01, "R5"},
        '{1'b1, 1'b0, 2'b11, 6'h24, 16'h0000, 1'b1, 16'h1234, 2'b11, "R5"},
        '{1'b1, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h0FF0, 2'b11, "R5"},
        '{1'b0, 1'b0, 2'b11, 6'h20, 16'h0000, 1'b1, 16'h1234, 2'b11, "R2"},
        '{1'b0, 1'b1, 2'b01, 6'h21, 16'h00AB, 1'b0, 16'h0000, 2'b11, "R3"},
        '{1'b1, 1'b0, 2'b11, 6'h25, 16'h0000, 1'b1, 16'h00AB, 2'b11, "R1"},
        '{1'b1, 1'b1, 2'b01, 6'h28, 16'h0004, 1'b0, 16'h0000, 2'b11, "R7"},
        '{1'b0, 1'b1, 2'b10, 6'h22, 16'h5600, 1'b0, 16'h0000, 2'b11, "R7"},
        '{1'b1, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h0BF4, 2'b11, "R7"},
        '{1'b0, 1'b1, 2'b11, 6'h3F, 16'hFFFF, 1'b0, 16'h0000, 2'b11, "R9"},
        '{1'b0, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h0FF0, 2'b11, "R9"},
        '{1'b0, 1'b1, 2'b10, 6'h28, 16'h000F, 1'b0, 16'h0000, 2'b11, "R6"},
        '{1'b0, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h0FF0, 2'b11, "R6"},
        '{1'b1, 1'b1, 2'b11, 6'h23, 16'hBEEF, 1'b0, 16'h0000, 2'b10, "R8"},
        '{1'b0, 1'b1, 2'b01, 6'h28, 16'h000F, 1'b0, 16'h0000, 2'b11, "R8"},
        '{1'b0, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h077F, 2'b11, "R7"},
        '{1'b0, 1'b1, 2'b01, 6'h28, 16'h0000, 1'b0, 16'h0000, 2'b10, "R8"},
        '{1'b0, 1'b0, 2'b11, 6'h27, 16'h0000, 1'b1, 16'hBEEF, 2'b11, "R5"},
        '{1'b1, 1'b0, 2'b10, 6'h26, 16'h0000, 1'b1, 16'h5600, 2'b11, "R5"},
        '{1'b1, 1'b0, 2'b11, 6'h28, 16'h0000, 1'b1, 16'h0FF4, 2'b11, "R6"},
        '{1'b0, 1'b1, 2'b10, 6'h21, 16'hCD00, 1'b0, 16'h0000, 2'b01, "R1"},
        '{1'b1, 1'b0, 2'b01, 6'h25, 16'h0000, 1'b1, 16'hCDAB, 2'b01, "R1"},
        '{1'b0, 1'b1, 2'b11, 6'h30, 16'h0000, 1'b1, 16'hBEEF, 2'b01, "R12"},
        '{1'b1, 1'b0, 2'b11, 6'h25, 16'h0000, 1'b1, 16'hCDAB, 2'b11, "R5"}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one access (from a falling edge), return at the next falling edge
    task automatic access(input logic port, input logic wr, input logic [1:0] be,
                          input logic [5:0] addr, input logic [15:0] wd);
        if (!port) begin
            a_sel = 1'b1; a_wr = wr; a_be = be; a_addr = addr; a_wdata = wd;
        end else begin
            b_sel = 1'b1; b_wr = wr; b_be = be; b_addr = addr; b_wdata = wd;
        end
        @(negedge clk);
        a_sel = 1'b0;
        b_sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: state after reset
        check("R10", {14'b0, b_irq_n, a_irq_n}, 16'h0003);
        check("R10", a_rdata, 16'h0000);
        access(1'b0, 1'b0, 2'b11, 6'h28, 16'h0);
        check("R10", a_rdata, 16'h0FFF);
        access(1'b1, 1'b0, 2'b11, 6'h24, 16'h0);
        check("R10", b_rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].port, VEC[i].wr, VEC[i].be, VEC[i].addr, VEC[i].wd);
            check(string'(VEC[i].tag), {14'b0, b_irq_n, a_irq_n}, {14'b0, VEC[i].irq});
            if (VEC[i].chk)
                check(string'(VEC[i].tag), VEC[i].port ? b_rdata : a_rdata, VEC[i].rd);
        end

        // R11: set and clear of A's mailbox 0 collide in one cycle
        a_sel = 1'b1; a_wr = 1'b1; a_be = 2'b11; a_addr = 6'h20; a_wdata = 16'h7777;
        b_sel = 1'b1; b_wr = 1'b0; b_be = 2'b11; b_addr = 6'h24;
        @(negedge clk);
        a_sel = 1'b0; b_sel = 1'b0;
        check("R11", {14'b0, b_irq_n, a_irq_n}, 16'h0001);
        check("R11", b_rdata, 16'h1234);
        access(1'b1, 1'b0, 2'b11, 6'h24, 16'h0);
        check("R2", b_rdata, 16'h7777);
        check("R5", {14'b0, b_irq_n, a_irq_n}, 16'h0003);

        // R10: reset in mid-run restores everything
        access(1'b1, 1'b1, 2'b11, 6'h22, 16'h9999);
        check("R3", {14'b0, b_irq_n, a_irq_n}, 16'h0002);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", {14'b0, b_irq_n, a_irq_n}, 16'h0003);
        access(1'b0, 1'b0, 2'b11, 6'h26, 16'h0);
        check("R10", a_rdata, 16'h0000);
        access(1'b0, 1'b0, 2'b11, 6'h28, 16'h0);
        check("R10", a_rdata, 16'h0FFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule